// File: doc/BRIEF.md
# Sync Sequence Watchdog

This block supervises the pair of synchronisation strobes that steer a secondary-side rectifier driver. One strobe marks a positive sync edge and the other a negative one. In normal operation they alternate. Each properly sequenced negative strobe restarts a cycle counter and produces an internal restart pulse of fixed length. If the count climbs to a runtime threshold, a timeout flag rises so that downstream logic can turn off both gate drivers.

The block also checks the order of the strobes. A negative strobe restarts the count only if a positive strobe has arrived since the previous negative one. A run of same-polarity pulses therefore leaves the count running, and the timeout still fires. A strobe seen alone from one detector cannot restart the timer. Strobes seen together in one cycle are treated as ambiguous and dropped.

The threshold should be set to roughly one primary switching period, expressed in clock cycles. A disable input turns the whole timeout function off.

Top module: `sync_seq_watchdog`

## Requirements
- R1: While reset is held (rst_n low at a clock edge), timeout_o and rst_pulse_o are 0, and the sequence tracker is left in the state that waits for a positive strobe.
- R2: A negative strobe sampled while armed (a positive strobe was seen since the last negative one) is a valid restart. rst_pulse_o is high for exactly PULSE_CYC cycles, starting after the edge that samples the strobe.
- R3: The counter saturates at the latched threshold and never wraps. Once timeout_o is high it stays high until a valid restart, a disable or a reset.
- R4: With threshold T and no further restart, timeout_o first reads 1 after the (PULSE_CYC+T)-th rising edge following the edge that sampled the restarting negative strobe. After reset release with no restart, it first reads 1 after the T-th rising edge.
- R5: A negative strobe with no positive strobe since the previous negative one does not restart the timer. No pulse appears, and the timeout time is unchanged.
- R6: After reset, a negative strobe that comes before any positive strobe is not a valid restart.
- R7: A cycle in which both strobes are high is ignored. It neither arms nor disarms the tracker and gives no restart.
- R8: A valid restart clears an asserted timeout_o after the edge that samples the negative strobe.
- R9: While tmr_dis_i is 1, timeout_o is 0 and the count is held at zero. After tmr_dis_i returns to 0, timeout_o first reads 1 after the T-th rising edge.
- R10: thr_i is latched only at reset and at a valid restart. A change at other times affects only the period after the next restart.
- R11: A valid restart during an active restart pulse retriggers the pulse, which then lasts PULSE_CYC cycles from the new restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pos_evt_i | input | 1 | Positive sync edge strobe |
| neg_evt_i | input | 1 | Negative sync edge strobe |
| thr_i | input | THR_W | Timeout threshold in clock cycles |
| tmr_dis_i | input | 1 | 1 disables the timeout function |
| timeout_o | output | 1 | Timeout flag, disables the drivers |
| rst_pulse_o | output | 1 | Internal timer restart pulse |

## Verification
The bench builds the block with PULSE_CYC = 3 and THR_W = 8, and uses thresholds of 10 and 4. With these values a whole restart-to-timeout window spans only about fifteen cycles. The short pulse lets a second valid restart be placed inside an active pulse to observe the retrigger, and lets a stray negative strobe be placed between the pulse end and the expiry. Because the two thresholds differ, a mid-period threshold change is visible: expiry follows the old value, and the new value applies only after the next restart.

// File: rtl/syncwd_pkg.sv
// Shared types for the sync sequence watchdog.
package syncwd_pkg;
    // Sequence tracker state: waiting for a positive strobe, or armed.
    typedef enum logic {
        SEQ_WAIT_POS = 1'b0,
        SEQ_ARMED    = 1'b1
    } seq_state_e;
endpackage

// File: rtl/syncwd_seq.sv
// Sequence tracker. Issues a restart strobe for a negative event only when a
// positive event has been seen since the previous negative event.
// Assumes: event strobes are single-cycle and already synchronised to clk.
// Both strobes high in one cycle is ambiguous and ignored.
module syncwd_seq
    import syncwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pos_i,
    input  logic neg_i,
    output logic restart_o
);
    seq_state_e state_q;

    // Valid restart: armed, negative strobe, and no positive strobe with it.
    assign restart_o = (state_q == SEQ_ARMED) && neg_i && !pos_i;

    // Track whether a positive strobe came after the last negative strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_WAIT_POS;
        end else if (pos_i && !neg_i) begin
            state_q <= SEQ_ARMED;
        end else if (neg_i && !pos_i) begin
            state_q <= SEQ_WAIT_POS;
        end
    end

    p_restart_disarms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> (state_q == SEQ_WAIT_POS));
    p_simul_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i && neg_i) |=> $stable(state_q));
    p_pos_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i && !neg_i) |=> (state_q == SEQ_ARMED));
endmodule

// File: rtl/syncwd_pulse.sv
// Restart pulse generator. Stretches each restart strobe into a pulse that is
// PULSE_CYC cycles long. A new strobe reloads the length.
// Assumes: PULSE_CYC >= 1.
module syncwd_pulse #(
    parameter int PULSE_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic pulse_o
);
    localparam int PCNT_W = $clog2(PULSE_CYC + 1);

    logic              pulse_q;
    logic [PCNT_W-1:0] pcnt_q;

    assign pulse_o = pulse_q;

    // Load the length on restart, count down while the pulse is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            pcnt_q  <= '0;
        end else if (restart_i) begin
            pulse_q <= 1'b1;
            pcnt_q  <= PCNT_W'(PULSE_CYC - 1);
        end else if (pulse_q) begin
            if (pcnt_q == '0) begin
                pulse_q <= 1'b0;
            end else begin
                pcnt_q <= pcnt_q - 1'b1;
            end
        end
    end

    p_pulse_on_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> pulse_o);
    p_pulse_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && (pcnt_q != '0)) |=> pulse_q);
endmodule

// File: rtl/syncwd_count.sv
// Saturating timeout counter with a threshold latch. It clears while the
// restart pulse is active or the function is disabled, and latches the
// threshold at reset and at each restart.
// Assumes: restart_i starts pulse_i on the following cycle.
module syncwd_count #(
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             pulse_i,
    input  logic             dis_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             timeout_o
);
    logic [THR_W-1:0] cnt_q;
    logic [THR_W-1:0] thr_q;

    // Flag expiry only when enabled and outside a restart pulse.
    assign timeout_o = !dis_i && !pulse_i && (cnt_q == thr_q);

    // Latch the threshold and run the count, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            thr_q <= thr_i;
        end else begin
            if (restart_i) begin
                thr_q <= thr_i;
            end
            if (dis_i || pulse_i || restart_i) begin
                cnt_q <= '0;
            end else if (cnt_q != thr_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= thr_q);
    p_timeout_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !restart_i && !dis_i) |=> (timeout_o || dis_i));
    p_disable_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |-> !timeout_o);
    p_thr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |=> $stable(thr_q));
endmodule

// File: rtl/sync_seq_watchdog.sv
// Sync sequence watchdog top. Connects the sequence tracker, the restart pulse
// generator and the timeout counter.
// Assumes: strobes are synchronous single-cycle pulses, and thr_i is in clock
// cycles (about one primary switching period).
module sync_seq_watchdog #(
    parameter int THR_W     = 16,
    parameter int PULSE_CYC = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pos_evt_i,
    input  logic             neg_evt_i,
    input  logic [THR_W-1:0] thr_i,
    input  logic             tmr_dis_i,
    output logic             timeout_o,
    output logic             rst_pulse_o
);
    logic restart;
    logic pulse;

    syncwd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos_i     (pos_evt_i),
        .neg_i     (neg_evt_i),
        .restart_o (restart)
    );

    syncwd_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .pulse_o   (pulse)
    );

    syncwd_count #(.THR_W(THR_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .pulse_i   (pulse),
        .dis_i     (tmr_dis_i),
        .thr_i     (thr_i),
        .timeout_o (timeout_o)
    );

    assign rst_pulse_o = pulse;

    p_pulse_masks_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse_o |-> !timeout_o);
endmodule

// File: tb/test_sync_seq_watchdog.sv
module test_sync_seq_watchdog;
    localparam int THR_W = 8;
    localparam int P     = 3;
    localparam int T     = 10;
    localparam int T2    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pos = 1'b0;
    logic             neg = 1'b0;
    logic [THR_W-1:0] thr = THR_W'(T);
    logic             dis = 1'b0;
    logic             timeout;
    logic             rpulse;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sync_seq_watchdog #(.THR_W(THR_W), .PULSE_CYC(P)) i_sync_seq_watchdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .pos_evt_i   (pos),
        .neg_evt_i   (neg),
        .thr_i       (thr),
        .tmr_dis_i   (dis),
        .timeout_o   (timeout),
        .rst_pulse_o (rpulse)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reset with a given threshold. Ends at the release negedge (r0).
    task automatic apply_reset(input int th);
        @(negedge clk);
        thr = THR_W'(th); pos = 0; neg = 0; dis = 0; rst_n = 0;
        tick(3);
        chk(timeout, 1'b0, "R1 timeout in reset");
        chk(rpulse, 1'b0, "R1 pulse in reset");
        rst_n = 1;
    endtask

    // Positive then negative strobe. Ends at n1, just after the sampling edge.
    task automatic do_restart();
        @(negedge clk); pos = 1;
        @(negedge clk); pos = 0; neg = 1;
        @(negedge clk); neg = 0;
    endtask

    task automatic t_reset_lone_neg();
        apply_reset(T);
        neg = 1; tick(1); neg = 0;                  // r1
        chk(rpulse, 1'b0, "R6 lone negative after reset");
        tick(T - 2);                                // r_{T-1}
        chk(timeout, 1'b0, "R4 before expiry after reset");
        tick(1);                                    // r_T
        chk(timeout, 1'b1, "R4 expiry after reset");
    endtask

    task automatic t_restart();
        apply_reset(T);
        do_restart();                               // n1
        chk(rpulse, 1'b1, "R2 pulse starts");
        chk(timeout, 1'b0, "R8 timeout cleared by restart");
        tick(P - 1);                                // nP
        chk(rpulse, 1'b1, "R2 pulse last cycle");
        tick(1);
        chk(rpulse, 1'b0, "R2 pulse ended");
        tick(T - 1);                                // n_{P+T}
        chk(timeout, 1'b0, "R4 one before expiry");
        tick(1);
        chk(timeout, 1'b1, "R4 expiry");
        tick(20);
        chk(timeout, 1'b1, "R3 saturated timeout held");
    endtask

    task automatic t_double_neg();
        apply_reset(T);
        do_restart();                               // n1
        tick(P + 3);                                // n_{P+4}
        neg = 1; tick(1); neg = 0;                  // n_{P+5}
        chk(rpulse, 1'b0, "R5 repeated negative no pulse");
        tick(T - 5);                                // n_{P+T}
        chk(timeout, 1'b0, "R5 before original expiry");
        tick(1);
        chk(timeout, 1'b1, "R5 expiry unchanged");
        do_restart();
        chk(timeout, 1'b0, "R8 positive reappears clears timeout");
        chk(rpulse, 1'b1, "R8 restart pulse");
    endtask

    task automatic t_simul();
        apply_reset(T);
        pos = 1; neg = 1; tick(1); pos = 0; neg = 0;
        tick(1);
        neg = 1; tick(1); neg = 0;
        chk(rpulse, 1'b0, "R7 simultaneous strobes do not arm");
        pos = 1; tick(1); pos = 0;
        pos = 1; neg = 1; tick(1); pos = 0; neg = 0;
        chk(rpulse, 1'b0, "R7 simultaneous strobes no restart");
        neg = 1; tick(1); neg = 0;
        chk(rpulse, 1'b1, "R7 simultaneous strobes keep armed");
    endtask

    task automatic t_disable();
        apply_reset(T);
        dis = 1;
        tick(30);
        chk(timeout, 1'b0, "R9 disabled no timeout");
        dis = 0;                                    // m0
        tick(T - 1);
        chk(timeout, 1'b0, "R9 count restarted from zero");
        tick(1);
        chk(timeout, 1'b1, "R9 expiry after enable");
    endtask

    task automatic t_threshold();
        apply_reset(T);
        do_restart();                               // n1
        thr = THR_W'(T2);
        tick(P + T2);                               // n_{P+T2+1}
        chk(timeout, 1'b0, "R10 new threshold not yet used");
        tick(T - T2 - 1);                           // n_{P+T}
        chk(timeout, 1'b0, "R10 before old expiry");
        tick(1);
        chk(timeout, 1'b1, "R10 old threshold expiry");
        do_restart();                               // n1
        tick(P + T2 - 1);                           // n_{P+T2}
        chk(timeout, 1'b0, "R10 before new expiry");
        tick(1);
        chk(timeout, 1'b1, "R10 new threshold after restart");
    endtask

    task automatic t_retrigger();
        apply_reset(T);
        do_restart();                               // n1
        pos = 1; tick(1); pos = 0; neg = 1;         // n2
        tick(1); neg = 0;                           // n3
        tick(P - 1);                                // n_{P+2}
        chk(rpulse, 1'b1, "R11 retriggered pulse still high");
        tick(1);
        chk(rpulse, 1'b0, "R11 retriggered pulse ends");
        tick(T - 1);                                // n_{P+T+2}
        chk(timeout, 1'b0, "R11 before shifted expiry");
        tick(1);
        chk(timeout, 1'b1, "R11 shifted expiry");
    endtask

    initial begin
        t_reset_lone_neg();
        t_restart();
        t_double_neg();
        t_simul();
        t_disable();
        t_threshold();
        t_retrigger();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule